// File: doc/BRIEF.md
# Redundant Reference Clock Failover Controller

This block supervises two candidate reference clocks against a feedback clock and decides which of the two should drive a downstream phase-locked loop. All three monitored clocks arrive as plain signals and are sampled by one fast system clock. Each passes through a synchronizer and an edge detector. A reference that shows no edge across a full feedback period is marked bad. The mark stays set until a one-shot alarm reset or a master reset clears it.

With automatic switching enabled, a failure of the active reference moves the selection to the other input and freezes it. With manual override, the selection always tracks `sel_clk`, and the bad flags keep working. Every change of selection starts a small switch sequencer. It waits for the next falling edge of the newly chosen input, then waits for one rising edge of both the feedback clock and that input. It then emits a one-cycle `switch_event` pulse.

The sequencer states are:
- SW_IDLE: no switch pending.
- SW_WAIT_FALL: waiting for a falling edge of the new reference.
- SW_WAIT_PAIR: collecting the rising edges of the feedback clock and the new reference.
- SW_DONE: one cycle in which the event is raised.

The sequencer moves through these transitions:
- SW_IDLE goes to SW_WAIT_FALL when the selection changes. Any state does the same on a new selection change.
- SW_WAIT_FALL goes to SW_WAIT_PAIR on a falling edge of the new reference.
- SW_WAIT_PAIR goes to SW_DONE once both rising edges have been seen.
- SW_DONE goes to SW_IDLE after one cycle.

Top module: `fo_clock_failover`

## Requirements
- R1: An input is declared failed when it shows no edge across one full feedback period, measured either rising-to-rising or falling-to-falling. An input that keeps toggling at the feedback rate is never flagged.
- R2: Once set, `inp0_bad` / `inp1_bad` stay high until an alarm reset pulse or master reset.
- R3: `clk_selected` is 0 when input 0 is the active reference and 1 when input 1 is. While no bad flag is set, it takes the value of `sel_clk` (0 selects input 0, 1 selects input 1) one sampling cycle after `sel_clk` changes.
- R4: With `man_override` low and no flag set, a failure of the active input sets its flag and moves `clk_selected` to the other input. A failure of the inactive input sets only its flag and leaves the selection unchanged.
- R5: With `man_override` high, `clk_selected` follows `sel_clk` even while an input is failed. Bad flags still latch.
- R6: With `man_override` low and any bad flag set, changes of `sel_clk` have no effect on `clk_selected`.
- R7: A falling edge of `alarm_rst_n` produces one internal pulse that clears both flags and loads `clk_selected` from `sel_clk`. Holding `alarm_rst_n` low afterwards does not clear flags that set later.
- R8: If both inputs fail in the same cycle with `man_override` low, both flags set and `clk_selected` becomes 0. After an alarm reset with both inputs still dead, both flags set again after a feedback period and `clk_selected` returns to 0.
- R9: Each change of `clk_selected` is followed by exactly one single-cycle `switch_event` pulse. The pulse comes after a falling edge of the new input and then a rising edge of both the feedback clock and the new input.
- R10: `rst_n` low asynchronously clears both flags and forces `clk_selected` to 0. After release, the selection takes `sel_clk` on the first clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock (at least 4x any monitored clock) |
| rst_n | input | 1 | Asynchronous active-low master reset |
| clk0_in | input | 1 | Reference input 0, sampled |
| clk1_in | input | 1 | Reference input 1, sampled |
| fb_in | input | 1 | Feedback clock, sampled |
| sel_clk | input | 1 | Primary reference choice: 0 = input 0, 1 = input 1 |
| man_override | input | 1 | 1 = selection always follows sel_clk |
| alarm_rst_n | input | 1 | Alarm reset, acts on its falling edge only |
| inp0_bad | output | 1 | Latched failure flag of input 0 |
| inp1_bad | output | 1 | Latched failure flag of input 1 |
| clk_selected | output | 1 | Active reference: 0 = input 0, 1 = input 1 |
| switch_event | output | 1 | One-cycle pulse when a switch has realigned |

## Verification
A change of `sel_clk` shows on `clk_selected` one sampling cycle later. The bench checks it after a few cycles, within a span where nothing else can change it. An alarm falling edge takes two synchronizer stages, an edge register and the latch, so the flags clear four cycles after the edge. The next re-detection of a dead input cannot come before about nine cycles, and the bench samples in that gap. A failure becomes visible four sampling cycles after the feedback edge that closes an edge-free window, so up to two feedback periods after a clock stops. The bench therefore waits five feedback periods before comparing. The `switch_event` count is compared only after a settling span that covers the falling-edge wait and the rising-edge pair, with no other selection change in between.

// File: rtl/fo_pkg.sv
package fo_pkg;

    localparam int NREF   = 2;
    localparam int NMON   = NREF + 1;
    localparam int FB_IDX = NREF;

    typedef struct packed {
        logic lvl;
        logic rise;
        logic fall;
    } edge_t;

    typedef enum logic [1:0] {
        SW_IDLE,
        SW_WAIT_FALL,
        SW_WAIT_PAIR,
        SW_DONE
    } sw_state_t;

endpackage

// File: rtl/fo_edge_sync.sv
module fo_edge_sync
    import fo_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  din,
    output edge_t ev
);

    logic [STAGES-1:0] sh;
    logic              last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh   <= '0;
            last <= 1'b0;
        end else begin
            sh   <= {sh[STAGES-2:0], din};
            last <= sh[STAGES-1];
        end
    end

    always_comb begin
        ev.lvl  = sh[STAGES-1];
        ev.rise = sh[STAGES-1] & ~last;
        ev.fall = ~sh[STAGES-1] & last;
    end

endmodule

// File: rtl/fo_loss_monitor.sv
module fo_loss_monitor
    import fo_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  restart,
    input  edge_t mon_ev,
    input  edge_t fb_ev,
    output logic  fail
);

    logic seen_r, seen_f;
    logic arm_r, arm_f;
    logic mon_edge;

    assign mon_edge = mon_ev.rise | mon_ev.fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_r <= 1'b0;
            seen_f <= 1'b0;
            arm_r  <= 1'b0;
            arm_f  <= 1'b0;
            fail   <= 1'b0;
        end else if (restart) begin
            seen_r <= 1'b0;
            seen_f <= 1'b0;
            arm_r  <= 1'b0;
            arm_f  <= 1'b0;
            fail   <= 1'b0;
        end else begin
            fail <= (fb_ev.rise && arm_r && !seen_r && !mon_edge) ||
                    (fb_ev.fall && arm_f && !seen_f && !mon_edge);
            if (fb_ev.rise) begin
                arm_r  <= 1'b1;
                seen_r <= mon_edge;
            end else if (mon_edge) begin
                seen_r <= 1'b1;
            end
            if (fb_ev.fall) begin
                arm_f  <= 1'b1;
                seen_f <= mon_edge;
            end else if (mon_edge) begin
                seen_f <= 1'b1;
            end
        end
    end

    // a restart wipes any pending window, so no failure can follow it directly (R1)
    p_restart_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !fail);

endmodule

// File: rtl/fo_alarm_oneshot.sv
module fo_alarm_oneshot #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic alarm_n,
    output logic pulse
);

    logic [STAGES-1:0] sh;
    logic              last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh    <= '1;
            last  <= 1'b1;
            pulse <= 1'b0;
        end else begin
            sh    <= {sh[STAGES-2:0], alarm_n};
            last  <= sh[STAGES-1];
            pulse <= last & ~sh[STAGES-1];
        end
    end

    p_one_shot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);

endmodule

// File: rtl/fo_failover_ctrl.sv
module fo_failover_ctrl
    import fo_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sel_clk,
    input  logic            man_override,
    input  logic            alarm,
    input  logic [NREF-1:0] fail,
    input  logic [NREF-1:0] ref_rise,
    input  logic [NREF-1:0] ref_fall,
    input  logic            fb_rise,
    output logic [NREF-1:0] bad,
    output logic            sel,
    output logic            switch_event
);

    logic [NREF-1:0] bad_nxt;
    logic            sel_nxt;
    sw_state_t       st, st_nxt;
    logic            got_fb, got_ref;
    logic            pair_done;

    // selection and flag next values
    always_comb begin
        bad_nxt = bad | fail;
        sel_nxt = sel;
        if (alarm) begin
            bad_nxt = '0;
            sel_nxt = sel_clk;
        end else if (man_override) begin
            sel_nxt = sel_clk;
        end else if (bad == '0) begin
            if (fail == '1)
                sel_nxt = 1'b0;
            else if (fail[sel])
                sel_nxt = ~sel;
            else if (fail != '0)
                sel_nxt = sel;
            else
                sel_nxt = sel_clk;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bad <= '0;
            sel <= 1'b0;
        end else begin
            bad <= bad_nxt;
            sel <= sel_nxt;
        end
    end

    // switch sequencer: next state
    assign pair_done = (got_fb | fb_rise) & (got_ref | ref_rise[sel]);

    always_comb begin
        st_nxt = st;
        if (sel_nxt != sel) begin
            st_nxt = SW_WAIT_FALL;
        end else begin
            unique case (st)
                SW_IDLE:      st_nxt = SW_IDLE;
                SW_WAIT_FALL: if (ref_fall[sel]) st_nxt = SW_WAIT_PAIR;
                SW_WAIT_PAIR: if (pair_done) st_nxt = SW_DONE;
                SW_DONE:      st_nxt = SW_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st      <= SW_IDLE;
            got_fb  <= 1'b0;
            got_ref <= 1'b0;
        end else begin
            st <= st_nxt;
            if (st == SW_WAIT_PAIR && st_nxt == SW_WAIT_PAIR) begin
                got_fb  <= got_fb | fb_rise;
                got_ref <= got_ref | ref_rise[sel];
            end else begin
                got_fb  <= 1'b0;
                got_ref <= 1'b0;
            end
        end
    end

    // outputs
    always_comb begin
        switch_event = (st == SW_DONE);
    end

    p_flag0_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bad[0] && !alarm |=> bad[0]);
    p_flag1_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bad[1] && !alarm |=> bad[1]);
    p_override_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        man_override |=> sel == $past(sel_clk));
    p_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !man_override && (bad != '0) && !alarm |=> $stable(sel));
    p_alarm_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        alarm |=> (bad == '0) && (sel == $past(sel_clk)));
    p_both_dead_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !man_override && !alarm && (bad == '0) && (fail == '1) |=> !sel && (bad == '1));
    p_event_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        switch_event |=> !switch_event);

endmodule

// File: rtl/fo_clock_failover.sv
module fo_clock_failover
    import fo_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clk0_in,
    input  logic clk1_in,
    input  logic fb_in,
    input  logic sel_clk,
    input  logic man_override,
    input  logic alarm_rst_n,
    output logic inp0_bad,
    output logic inp1_bad,
    output logic clk_selected,
    output logic switch_event
);

    logic [NMON-1:0] raw;
    edge_t           ev [NMON];
    logic [NREF-1:0] fail;
    logic [NREF-1:0] ref_rise, ref_fall;
    logic [NREF-1:0] bad;
    logic            alarm_pulse;

    assign raw = {fb_in, clk1_in, clk0_in};

    for (genvar gi = 0; gi < NMON; gi++) begin : g_sync
        fo_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (raw[gi]),
            .ev    (ev[gi])
        );
    end

    for (genvar gr = 0; gr < NREF; gr++) begin : g_mon
        assign ref_rise[gr] = ev[gr].rise;
        assign ref_fall[gr] = ev[gr].fall;
        fo_loss_monitor u_mon (
            .clk     (clk),
            .rst_n   (rst_n),
            .restart (alarm_pulse),
            .mon_ev  (ev[gr]),
            .fb_ev   (ev[FB_IDX]),
            .fail    (fail[gr])
        );
    end

    fo_alarm_oneshot #(.STAGES(SYNC_STAGES)) u_alarm (
        .clk     (clk),
        .rst_n   (rst_n),
        .alarm_n (alarm_rst_n),
        .pulse   (alarm_pulse)
    );

    fo_failover_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .sel_clk      (sel_clk),
        .man_override (man_override),
        .alarm        (alarm_pulse),
        .fail         (fail),
        .ref_rise     (ref_rise),
        .ref_fall     (ref_fall),
        .fb_rise      (ev[FB_IDX].rise),
        .bad          (bad),
        .sel          (clk_selected),
        .switch_event (switch_event)
    );

    assign inp0_bad = bad[0];
    assign inp1_bad = bad[1];

endmodule

// File: tb/fo_clock_failover_tb.sv
module fo_clock_failover_tb;

    typedef struct {
        string req;
        logic  b0, b1, sel;
        bit    chk_ev;
        int    ev_exp;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic c0 = 1'b0, c1 = 1'b0, fb = 1'b0;
    logic sel_clk = 1'b0, man_override = 1'b0, alarm_rst_n = 1'b1;
    logic inp0_bad, inp1_bad, clk_selected, switch_event;
    bit   run0 = 1, run1 = 1;
    int   n_chk = 0, n_bad = 0, ev_cnt = 0, ev_base = 0;
    bit   finished = 0;
    exp_t exp_q[$];

    always #2 clk = ~clk;

    initial begin #3;  forever begin #16; if (run0) c0 = ~c0; end end
    initial begin #7;  forever begin #16; if (run1) c1 = ~c1; end end
    initial begin #11; forever begin #16; fb = ~fb; end end

    fo_clock_failover u_dut (
        .clk(clk), .rst_n(rst_n), .clk0_in(c0), .clk1_in(c1), .fb_in(fb),
        .sel_clk(sel_clk), .man_override(man_override), .alarm_rst_n(alarm_rst_n),
        .inp0_bad(inp0_bad), .inp1_bad(inp1_bad), .clk_selected(clk_selected),
        .switch_event(switch_event)
    );

    // monitor: counts events and scores queued expectations mid-cycle
    always @(negedge clk) begin
        if (rst_n && switch_event) ev_cnt++;
        while (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_chk++;
            if (e.chk_ev) begin
                if (ev_cnt != e.ev_exp) begin
                    n_bad++;
                    $display("FAIL %s: switch events actual %0d expected %0d", e.req, ev_cnt, e.ev_exp);
                end
            end else if ({inp0_bad, inp1_bad, clk_selected} !== {e.b0, e.b1, e.sel}) begin
                n_bad++;
                $display("FAIL %s: bad0/bad1/sel actual %b%b%b expected %b%b%b",
                         e.req, inp0_bad, inp1_bad, clk_selected, e.b0, e.b1, e.sel);
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic expect_st(input string r, input logic b0, input logic b1, input logic s);
        exp_t e;
        e.req = r; e.b0 = b0; e.b1 = b1; e.sel = s; e.chk_ev = 0; e.ev_exp = 0;
        exp_q.push_back(e);
        @(negedge clk);
    endtask

    task automatic expect_ev(input string r, input int n);
        exp_t e;
        e.req = r; e.b0 = 0; e.b1 = 0; e.sel = 0; e.chk_ev = 1; e.ev_exp = n;
        exp_q.push_back(e);
        @(negedge clk);
    endtask

    task automatic alarm_pulse();
        @(negedge clk) alarm_rst_n = 1'b0;
        cyc(6);
        @(negedge clk) alarm_rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        cyc(100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not complete, actual timeout expected finish");
        finish_run();
    end

    initial begin
        cyc(5);
        expect_st("R10", 0, 0, 0);                  // reset state
        @(negedge clk) rst_n = 1'b1;
        cyc(60);
        expect_st("R1", 0, 0, 0);                   // live inputs never flagged

        // R3 free selection and R9 event per change
        ev_base = ev_cnt;
        @(negedge clk) sel_clk = 1'b1;
        cyc(2);
        expect_st("R3", 0, 0, 1);
        cyc(40);
        expect_ev("R9", ev_base + 1);
        ev_base = ev_cnt;
        @(negedge clk) sel_clk = 1'b0;
        cyc(2);
        expect_st("R3", 0, 0, 0);
        cyc(40);
        expect_ev("R9", ev_base + 1);

        // R4 active input 0 dies -> switch to input 1
        ev_base = ev_cnt;
        @(negedge clk) run0 = 0;
        cyc(40);
        expect_st("R4", 1, 0, 1);
        cyc(40);
        expect_ev("R9", ev_base + 1);

        // R6 frozen selection, R2 sticky flag even with input 0 back
        @(negedge clk) sel_clk = 1'b1;
        cyc(5);
        expect_st("R6", 1, 0, 1);
        @(negedge clk) sel_clk = 1'b0;
        cyc(5);
        expect_st("R6", 1, 0, 1);
        run0 = 1;
        cyc(100);
        expect_st("R2", 1, 0, 1);

        // R7 alarm edge clears and loads sel_clk; level held low has no effect
        @(negedge clk) alarm_rst_n = 1'b0;
        cyc(6);
        expect_st("R7", 0, 0, 0);
        @(negedge clk) run1 = 0;                    // inactive input dies
        cyc(40);
        expect_st("R7", 0, 1, 0);                   // flag set despite held alarm
        expect_st("R4", 0, 1, 0);                   // inactive failure: no switch
        @(negedge clk) begin alarm_rst_n = 1'b1; run1 = 1; end
        cyc(20);
        alarm_pulse();
        cyc(40);
        expect_st("R7", 0, 0, 0);

        // R5 override: flags latch, no auto switch, sel follows sel_clk
        @(negedge clk) begin man_override = 1'b1; run0 = 0; end
        cyc(40);
        expect_st("R5", 1, 0, 0);
        @(negedge clk) sel_clk = 1'b1;
        cyc(3);
        expect_st("R5", 1, 0, 1);
        @(negedge clk) sel_clk = 1'b0;
        cyc(3);
        expect_st("R5", 1, 0, 0);
        @(negedge clk) begin run0 = 1; man_override = 1'b0; end
        cyc(20);
        alarm_pulse();
        cyc(40);
        expect_st("R5", 0, 0, 0);

        // R8 both inputs die together
        @(negedge clk) sel_clk = 1'b1;
        cyc(40);
        expect_st("R3", 0, 0, 1);
        @(negedge clk) begin run0 = 0; run1 = 0; end
        cyc(40);
        expect_st("R8", 1, 1, 0);
        @(negedge clk) alarm_rst_n = 1'b0;
        cyc(5);
        expect_st("R7", 0, 0, 1);
        cyc(40);
        expect_st("R8", 1, 1, 0);
        @(negedge clk) alarm_rst_n = 1'b1;

        // R10 asynchronous master reset mid-cycle
        @(posedge clk) #1 rst_n = 1'b0;
        expect_st("R10", 0, 0, 0);
        @(negedge clk) rst_n = 1'b1;
        cyc(2);
        expect_st("R10", 0, 0, 1);
        cyc(4);
        finish_run();
    end

endmodule